// File: doc/BRIEF.md
# Split Register Rename Map

This block is the register alias table of an out-of-order core. Architectural register numbers form one index space. The lowest indices are integer registers and the next range is floating-point registers. Every index above those is a miscellaneous register, and those are never renamed. Integer and floating-point registers each have their own mapping table and their own free-tag FIFO. Integer physical tags occupy `[0, INT_PHYS)` and floating-point tags occupy `[INT_PHYS, INT_PHYS+FP_PHYS)`.

Each cycle the block accepts at most one rename request. For an accepted request it reports the newly assigned physical tag and the tag the index held before. A combinational lookup port reads the current mapping. A set-entry port overwrites a mapping during recovery. A free port returns a retired tag to the matching FIFO. The block also reports rename capacity, which is the smaller of the two free counts.

Top module: `split_rename_map`

## Requirements
- R1: Renaming an integer index other than the integer zero register takes the head tag of the integer FIFO, which lies in [0, INT_PHYS). It returns the old mapping as the previous tag and writes the new tag into the integer table.
- R2: Renaming a float index other than the float zero register works the same way through the float FIFO. The new tag is `INT_PHYS + popped value`, which lies in [INT_PHYS, INT_PHYS+FP_PHYS).
- R3: Renaming the integer zero register (INT_ZERO) or the float zero register (FP_ZERO) returns that index value as the new tag and the current mapping as the previous tag. Neither table nor any FIFO changes.
- R4: An index a ≥ INT_LOG+FP_LOG is a miscellaneous register. Both its new and previous tag equal `INT_PHYS+FP_PHYS + a - (INT_LOG+FP_LOG)`, and a rename of it allocates nothing.
- R5: After reset, integer index i maps to INT_BASE+i and float index INT_LOG+j maps to FP_BASE+j. Each FIFO holds its class's remaining tags in ascending order with wraparound, starting just after the last bound tag.
- R6: A freed tag below INT_PHYS is pushed onto the integer FIFO. A freed tag below INT_PHYS+FP_PHYS has INT_PHYS subtracted and is pushed onto the float FIFO. A freed tag at or above INT_PHYS+FP_PHYS is ignored. Tags are handed out again in the order they were freed.
- R7: `free_cnt` equals the minimum of the integer and float FIFO occupancies as of the last clock edge.
- R8: A set-entry write to an integer or float index replaces that mapping from the next cycle on. A write to a miscellaneous index is ignored. When a set-entry and a rename target the same index in the same cycle, the set-entry value wins.
- R9: `rn_ready` is low exactly when the request needs a tag from an empty FIFO, and a request with `rn_ready` low is not taken. Zero-register and miscellaneous requests are always ready.
- R10: `lk_tag` follows `lk_arch` combinationally and shows the mapping before any write in the same cycle. `rn_done`, `rn_new_tag` and `rn_prev_tag` are registered and appear one cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rn_valid | input | 1 | Rename request valid |
| rn_arch | input | AW | Architectural index to rename |
| rn_ready | output | 1 | Request can be accepted this cycle |
| rn_done | output | 1 | Rename result valid (one cycle after acceptance) |
| rn_new_tag | output | TW | Newly assigned physical tag |
| rn_prev_tag | output | TW | Physical tag held before the rename |
| lk_arch | input | AW | Lookup index |
| lk_tag | output | TW | Current mapping of `lk_arch` |
| set_valid | input | 1 | Set-entry write enable |
| set_arch | input | AW | Set-entry index |
| set_tag | input | TW | Set-entry tag |
| free_valid | input | 1 | Freed tag valid |
| free_tag | input | TW | Tag being returned |
| free_cnt | output | CW | Rename capacity: min of the two free counts |

## Verification
The bench drives inputs just after a rising edge and checks `rn_ready`, `lk_tag` and `free_cnt` a few nanoseconds later, before the next edge. Those values depend only on the state after the last edge and on the current inputs. The rename result registers at the edge that accepts the request. The bench therefore compares `rn_done`, `rn_new_tag` and `rn_prev_tag` one nanosecond after that edge with values it computed from its own model before the edge. The model applies writes in a fixed order: first the rename pop and table write, then the set-entry write, then the free push. Because of that order, the effects of a set-entry and a freed tag show up in the next cycle's combinational checks.

// File: rtl/srm_pkg.sv
package srm_pkg;

  typedef enum logic [1:0] {
    RC_INT  = 2'd0,
    RC_FP   = 2'd1,
    RC_MISC = 2'd2
  } reg_class_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/srm_tag_fifo.sv
module srm_tag_fifo #(
  parameter  int DEPTH = 16,
  parameter  int FIRST = 0,
  parameter  int FILL  = 8,
  localparam int DW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count
);

  localparam logic [DW-1:0] LAST  = DW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] head, tail;
  logic          do_pop, do_push;

  assign do_pop   = pop && (count != '0);
  assign do_push  = push && ((count != FULLC) || do_pop);
  assign pop_data = mem[head];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= DW'((FIRST + k) % DEPTH);
      head  <= '0;
      tail  <= DW'(FILL % DEPTH);
      count <= CW'(FILL);
    end else begin
      if (do_push) begin
        mem[tail] <= push_data;
        tail      <= (tail == LAST) ? '0 : tail + 1'b1;
      end
      if (do_pop) head <= (head == LAST) ? '0 : head + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/srm_map_table.sv
module srm_map_table #(
  parameter  int N    = 8,
  parameter  int TW   = 6,
  parameter  int BASE = 0,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] ra_idx,
  output logic [TW-1:0] ra_tag,
  input  logic [IW-1:0] rb_idx,
  output logic [TW-1:0] rb_tag,
  input  logic          wa_en,
  input  logic [IW-1:0] wa_idx,
  input  logic [TW-1:0] wa_tag,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_idx,
  input  logic [TW-1:0] wb_tag
);

  logic [TW-1:0] mem [N];

  assign ra_tag = (int'(ra_idx) < N) ? mem[ra_idx] : '0;
  assign rb_tag = (int'(rb_idx) < N) ? mem[rb_idx] : '0;

  // Recovery write (port b) lands after, and so overrides, the rename write.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) mem[k] <= TW'(BASE + k);
    end else begin
      if (wa_en && int'(wa_idx) < N) mem[wa_idx] <= wa_tag;
      if (wb_en && int'(wb_idx) < N) mem[wb_idx] <= wb_tag;
    end
  end

endmodule

// File: rtl/split_rename_map.sv
module split_rename_map
  import srm_pkg::*;
#(
  parameter  int INT_LOG  = 8,
  parameter  int FP_LOG   = 8,
  parameter  int INT_PHYS = 16,
  parameter  int FP_PHYS  = 16,
  parameter  int MISC     = 4,
  parameter  int INT_ZERO = 0,
  parameter  int FP_ZERO  = 8,
  parameter  int INT_BASE = 0,
  parameter  int FP_BASE  = 16,
  localparam int LOG_TOT  = INT_LOG + FP_LOG,
  localparam int PHYS_TOT = INT_PHYS + FP_PHYS,
  localparam int AW       = $clog2(LOG_TOT + MISC),
  localparam int TW       = $clog2(PHYS_TOT + MISC),
  localparam int CW       = $clog2(imax(INT_PHYS, FP_PHYS) + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rn_valid,
  input  logic [AW-1:0] rn_arch,
  output logic          rn_ready,
  output logic          rn_done,
  output logic [TW-1:0] rn_new_tag,
  output logic [TW-1:0] rn_prev_tag,
  input  logic [AW-1:0] lk_arch,
  output logic [TW-1:0] lk_tag,
  input  logic          set_valid,
  input  logic [AW-1:0] set_arch,
  input  logic [TW-1:0] set_tag,
  input  logic          free_valid,
  input  logic [TW-1:0] free_tag,
  output logic [CW-1:0] free_cnt
);

  localparam int IIW  = (INT_LOG > 1) ? $clog2(INT_LOG) : 1;
  localparam int FIW  = (FP_LOG > 1) ? $clog2(FP_LOG) : 1;
  localparam int ITW  = (INT_PHYS > 1) ? $clog2(INT_PHYS) : 1;
  localparam int FTW  = (FP_PHYS > 1) ? $clog2(FP_PHYS) : 1;
  localparam int ICW  = $clog2(INT_PHYS + 1);
  localparam int FCW  = $clog2(FP_PHYS + 1);

  localparam logic [AW-1:0] A_INT_LOG = AW'(INT_LOG);
  localparam logic [AW-1:0] A_LOG_TOT = AW'(LOG_TOT);
  localparam logic [AW-1:0] A_IZERO   = AW'(INT_ZERO);
  localparam logic [AW-1:0] A_FZERO   = AW'(FP_ZERO);
  localparam logic [TW-1:0] T_INT     = TW'(INT_PHYS);
  localparam logic [TW-1:0] T_TOT     = TW'(PHYS_TOT);
  localparam logic [TW-1:0] T_LOG_TOT = TW'(LOG_TOT);

  function automatic reg_class_e classify(input logic [AW-1:0] a);
    if (a < A_INT_LOG)      return RC_INT;
    else if (a < A_LOG_TOT) return RC_FP;
    else                    return RC_MISC;
  endfunction

  function automatic logic [TW-1:0] misc_tag(input logic [AW-1:0] a);
    return T_TOT + TW'(a) - T_LOG_TOT;
  endfunction

  // Request decode
  reg_class_e rn_cls, lk_cls, set_cls;
  logic       need_int, need_fp, fire;

  assign rn_cls   = classify(rn_arch);
  assign lk_cls   = classify(lk_arch);
  assign set_cls  = classify(set_arch);
  assign need_int = (rn_cls == RC_INT) && (rn_arch != A_IZERO);
  assign need_fp  = (rn_cls == RC_FP)  && (rn_arch != A_FZERO);

  // Free lists
  logic [ITW-1:0] int_head;
  logic [FTW-1:0] fp_head;
  logic [ICW-1:0] int_cnt;
  logic [FCW-1:0] fp_cnt;
  logic           int_push, fp_push;

  assign rn_ready = !(need_int && int_cnt == '0) && !(need_fp && fp_cnt == '0);
  assign fire     = rn_valid && rn_ready;
  assign int_push = free_valid && (free_tag < T_INT);
  assign fp_push  = free_valid && (free_tag >= T_INT) && (free_tag < T_TOT);

  srm_tag_fifo #(
    .DEPTH(INT_PHYS), .FIRST((INT_BASE + INT_LOG) % INT_PHYS), .FILL(INT_PHYS - INT_LOG)
  ) u_int_free (
    .clk(clk), .rst(rst),
    .push(int_push), .push_data(ITW'(free_tag)),
    .pop(fire && need_int), .pop_data(int_head), .count(int_cnt)
  );

  srm_tag_fifo #(
    .DEPTH(FP_PHYS), .FIRST((FP_BASE - INT_PHYS + FP_LOG) % FP_PHYS), .FILL(FP_PHYS - FP_LOG)
  ) u_fp_free (
    .clk(clk), .rst(rst),
    .push(fp_push), .push_data(FTW'(free_tag - T_INT)),
    .pop(fire && need_fp), .pop_data(fp_head), .count(fp_cnt)
  );

  // Mapping tables
  logic [TW-1:0] int_rn_tag, int_lk_tag, fp_rn_tag, fp_lk_tag;
  logic [TW-1:0] new_c, prev_c;

  srm_map_table #(.N(INT_LOG), .TW(TW), .BASE(INT_BASE)) u_int_map (
    .clk(clk), .rst(rst),
    .ra_idx(IIW'(rn_arch)), .ra_tag(int_rn_tag),
    .rb_idx(IIW'(lk_arch)), .rb_tag(int_lk_tag),
    .wa_en(fire && need_int), .wa_idx(IIW'(rn_arch)), .wa_tag(new_c),
    .wb_en(set_valid && set_cls == RC_INT), .wb_idx(IIW'(set_arch)), .wb_tag(set_tag)
  );

  srm_map_table #(.N(FP_LOG), .TW(TW), .BASE(FP_BASE)) u_fp_map (
    .clk(clk), .rst(rst),
    .ra_idx(FIW'(rn_arch - A_INT_LOG)), .ra_tag(fp_rn_tag),
    .rb_idx(FIW'(lk_arch - A_INT_LOG)), .rb_tag(fp_lk_tag),
    .wa_en(fire && need_fp), .wa_idx(FIW'(rn_arch - A_INT_LOG)), .wa_tag(new_c),
    .wb_en(set_valid && set_cls == RC_FP), .wb_idx(FIW'(set_arch - A_INT_LOG)), .wb_tag(set_tag)
  );

  always_comb begin
    unique case (rn_cls)
      RC_INT: begin
        prev_c = int_rn_tag;
        new_c  = need_int ? TW'(int_head) : TW'(rn_arch);
      end
      RC_FP: begin
        prev_c = fp_rn_tag;
        new_c  = need_fp ? (TW'(fp_head) + T_INT) : TW'(rn_arch);
      end
      default: begin
        new_c  = misc_tag(rn_arch);
        prev_c = new_c;
      end
    endcase
  end

  always_comb begin
    unique case (lk_cls)
      RC_INT:  lk_tag = int_lk_tag;
      RC_FP:   lk_tag = fp_lk_tag;
      default: lk_tag = misc_tag(lk_arch);
    endcase
  end

  assign free_cnt = (CW'(int_cnt) < CW'(fp_cnt)) ? CW'(int_cnt) : CW'(fp_cnt);

  // Registered rename result
  always_ff @(posedge clk) begin
    if (rst) begin
      rn_done     <= 1'b0;
      rn_new_tag  <= '0;
      rn_prev_tag <= '0;
    end else begin
      rn_done <= fire;
      if (fire) begin
        rn_new_tag  <= new_c;
        rn_prev_tag <= prev_c;
      end
    end
  end

endmodule

// File: rtl/split_rename_map_chk.sv
module split_rename_map_chk #(
  parameter int INT_LOG  = 8,
  parameter int FP_LOG   = 8,
  parameter int INT_PHYS = 16,
  parameter int FP_PHYS  = 16,
  parameter int INT_ZERO = 0,
  parameter int FP_ZERO  = 8,
  parameter int AW       = 5,
  parameter int TW       = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          rn_valid,
  input logic [AW-1:0] rn_arch,
  input logic          rn_ready,
  input logic          rn_done,
  input logic [TW-1:0] rn_new_tag,
  input logic [TW-1:0] rn_prev_tag
);

  localparam logic [AW-1:0] A_INT_LOG = AW'(INT_LOG);
  localparam logic [AW-1:0] A_LOG_TOT = AW'(INT_LOG + FP_LOG);
  localparam logic [AW-1:0] A_IZERO   = AW'(INT_ZERO);
  localparam logic [AW-1:0] A_FZERO   = AW'(FP_ZERO);
  localparam logic [TW-1:0] T_INT     = TW'(INT_PHYS);
  localparam logic [TW-1:0] T_TOT     = TW'(INT_PHYS + FP_PHYS);
  localparam logic [TW-1:0] T_IZERO   = TW'(INT_ZERO);

  AST_INT_TAG_RANGE: assert property (@(posedge clk) disable iff (rst)
    rn_valid && rn_ready && rn_arch < A_INT_LOG && rn_arch != A_IZERO |=> rn_done && rn_new_tag < T_INT); // R1

  AST_FP_TAG_RANGE: assert property (@(posedge clk) disable iff (rst)
    rn_valid && rn_ready && rn_arch >= A_INT_LOG && rn_arch < A_LOG_TOT && rn_arch != A_FZERO
    |=> rn_done && rn_new_tag >= T_INT && rn_new_tag < T_TOT); // R2

  AST_INT_ZERO_TAG: assert property (@(posedge clk) disable iff (rst)
    rn_valid && rn_arch == A_IZERO |=> rn_done && rn_new_tag == T_IZERO); // R3

  AST_MISC_SAME_TAG: assert property (@(posedge clk) disable iff (rst)
    rn_valid && rn_arch >= A_LOG_TOT |=> rn_done && rn_new_tag == rn_prev_tag && rn_new_tag >= T_TOT); // R4

  AST_NO_STALL_FREE: assert property (@(posedge clk) disable iff (rst)
    rn_valid && (rn_arch >= A_LOG_TOT || rn_arch == A_IZERO || rn_arch == A_FZERO) |-> rn_ready); // R9

  AST_STALL_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    rn_valid && !rn_ready |=> !rn_done); // R9

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rn_done |-> $past(rn_valid && rn_ready)); // R10

endmodule

bind split_rename_map split_rename_map_chk #(
  .INT_LOG(INT_LOG), .FP_LOG(FP_LOG), .INT_PHYS(INT_PHYS), .FP_PHYS(FP_PHYS),
  .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO), .AW(AW), .TW(TW)
) u_chk (
  .clk(clk), .rst(rst), .rn_valid(rn_valid), .rn_arch(rn_arch), .rn_ready(rn_ready),
  .rn_done(rn_done), .rn_new_tag(rn_new_tag), .rn_prev_tag(rn_prev_tag)
);

// File: tb/split_rename_map_test.sv
module split_rename_map_test;

  localparam int INT_LOG = 8, FP_LOG = 8, INT_PHYS = 16, FP_PHYS = 16, MISC = 4;
  localparam int INT_ZERO = 0, FP_ZERO = 8, INT_BASE = 0, FP_BASE = 16;
  localparam int LOG_TOT = INT_LOG + FP_LOG, PHYS_TOT = INT_PHYS + FP_PHYS;
  localparam int AW = 5, TW = 6, CW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic          rn_valid, set_valid, free_valid;
  logic [AW-1:0] rn_arch, lk_arch, set_arch;
  logic [TW-1:0] set_tag, free_tag;
  logic          rn_ready, rn_done;
  logic [TW-1:0] rn_new_tag, rn_prev_tag, lk_tag;
  logic [CW-1:0] free_cnt;

  always #4 clk = ~clk;

  split_rename_map uut (
    .clk(clk), .rst(rst), .rn_valid(rn_valid), .rn_arch(rn_arch), .rn_ready(rn_ready),
    .rn_done(rn_done), .rn_new_tag(rn_new_tag), .rn_prev_tag(rn_prev_tag),
    .lk_arch(lk_arch), .lk_tag(lk_tag), .set_valid(set_valid), .set_arch(set_arch),
    .set_tag(set_tag), .free_valid(free_valid), .free_tag(free_tag), .free_cnt(free_cnt)
  );

  int checks = 0, errors = 0;
  int map_m [LOG_TOT];
  int iq[$], fq[$], pend[$];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lookup(input int a);
    if (a < LOG_TOT) return map_m[a];
    return PHYS_TOT + a - LOG_TOT;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < INT_LOG; i++) map_m[i] = INT_BASE + i;
    for (int j = 0; j < FP_LOG; j++) map_m[INT_LOG + j] = FP_BASE + j;
    iq.delete(); fq.delete(); pend.delete();
    for (int k = 0; k < INT_PHYS - INT_LOG; k++) iq.push_back((INT_BASE + INT_LOG + k) % INT_PHYS);
    for (int k = 0; k < FP_PHYS - FP_LOG; k++)
      fq.push_back(INT_PHYS + (FP_BASE - INT_PHYS + FP_LOG + k) % FP_PHYS);
  endtask

  task automatic do_reset();
    rst = 1'b1; rn_valid = 0; rn_arch = 0; lk_arch = 0; set_valid = 0; set_arch = 0;
    set_tag = 0; free_valid = 0; free_tag = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    model_reset();
  endtask

  // One clock: combinational checks before the edge, registered checks after it.
  task automatic tick();
    int a, need_i, need_f, rdy, fire, en, ep, sa, st, ft;
    bit sv, fv;
    string req;
    #3;
    a = int'(rn_arch);
    need_i = (a < INT_LOG) && (a != INT_ZERO);
    need_f = (a >= INT_LOG) && (a < LOG_TOT) && (a != FP_ZERO);
    rdy = !(need_i && iq.size() == 0) && !(need_f && fq.size() == 0);
    chk("R9 ready", int'(rn_ready), rdy);
    chk("R10 lookup", int'(lk_tag), exp_lookup(int'(lk_arch)));
    chk("R7 free_cnt", int'(free_cnt), imin(iq.size(), fq.size()));
    fire = rn_valid && rdy;
    ep = exp_lookup(a);
    if (need_i)        begin en = iq[0]; req = "R1"; end
    else if (need_f)   begin en = fq[0]; req = "R2"; end
    else if (a < LOG_TOT) begin en = a; req = "R3"; end
    else               begin en = ep; req = "R4"; end
    sv = set_valid; sa = int'(set_arch); st = int'(set_tag);
    fv = free_valid; ft = int'(free_tag);
    @(posedge clk);
    #1;
    if (fire) begin
      if (need_i) begin void'(iq.pop_front()); map_m[a] = en; pend.push_back(ep); end
      if (need_f) begin void'(fq.pop_front()); map_m[a] = en; pend.push_back(ep); end
    end
    if (sv && sa < LOG_TOT) map_m[sa] = st;
    if (fv) begin
      if (ft < INT_PHYS) iq.push_back(ft);
      else if (ft < PHYS_TOT) fq.push_back(ft);
    end
    chk("R10 done", int'(rn_done), fire);
    if (fire) begin
      chk({req, " new tag"}, int'(rn_new_tag), en);
      chk({req, " prev tag"}, int'(rn_prev_tag), ep);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    #3;
    chk("R10 reset done", int'(rn_done), 0);
    chk("R5 reset free_cnt", int'(free_cnt), 8);
    @(posedge clk); #1;

    // Constrained random traffic without set-entry writes
    for (int n = 0; n < 3000; n++) begin
      rn_valid   = ($urandom % 10) < 7;
      rn_arch    = AW'($urandom % (LOG_TOT + MISC));
      lk_arch    = AW'($urandom % (LOG_TOT + MISC));
      free_valid = 0;
      if (pend.size() != 0 && ($urandom % 2) == 1) begin
        free_valid = 1;
        free_tag = TW'(pend.pop_front());
      end
      tick();
    end
    rn_valid = 0; free_valid = 0;

    // Directed corner cases
    do_reset();
    for (int i = 0; i < LOG_TOT + MISC; i++) begin   // R5 reset bindings, R4 misc lookup
      lk_arch = AW'(i);
      #3 chk("R5 reset map", int'(lk_tag), (i < INT_LOG) ? INT_BASE + i :
             (i < LOG_TOT) ? FP_BASE + i - INT_LOG : PHYS_TOT + i - LOG_TOT);
      @(posedge clk); #1;
    end
    rn_valid = 1; rn_arch = 3; lk_arch = 3;
    for (int i = 0; i < INT_PHYS - INT_LOG; i++) tick();   // R1 drains integer FIFO
    #3 chk("R9 empty stall", int'(rn_ready), 0);
    chk("R1 lookup updated", int'(lk_tag), 15);
    @(posedge clk); #1;
    chk("R9 stalled not done", int'(rn_done), 0);
    rn_arch = AW'(INT_ZERO); tick();                        // R3 zero never stalls
    rn_arch = AW'(FP_ZERO); tick();                         // R3
    rn_arch = 18; tick();                                   // R4
    rn_arch = 9; tick();                                    // R2
    rn_valid = 0;
    free_valid = 1; free_tag = 34; tick();                  // R6 out-of-range ignored
    #3 chk("R6 ignored free", int'(free_cnt), 0);
    free_tag = 20; @(posedge clk); #1; fq.push_back(20);
    free_tag = 5;  @(posedge clk); #1; iq.push_back(5);
    free_valid = 0;
    #3 chk("R6 int return", int'(free_cnt), 1);
    @(posedge clk); #1;
    rn_valid = 1; rn_arch = 4; tick();                      // R6 reissues tag 5
    chk("R6 reissue", int'(rn_new_tag), 5);
    rn_valid = 0;
    set_valid = 1; set_arch = 6; set_tag = 30; tick();      // R8 int write
    set_arch = 17; set_tag = 1; lk_arch = 6; tick();        // R8 misc write ignored
    set_valid = 0; lk_arch = 17;
    #3 chk("R8 misc ignored", int'(lk_tag), 33);
    @(posedge clk); #1;
    rn_valid = 1; rn_arch = 10; set_valid = 1; set_arch = 10; set_tag = 2; tick();
    rn_valid = 0; set_valid = 0; lk_arch = 10;
    #3 chk("R8 set beats rename", int'(lk_tag), 2);
    @(posedge clk); #1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule